// File: doc/BRIEF.md
# DMA Data-Bus Handshake Controller

This block is the controller end of a handshake with an external DMA device. The device can ask for the shared data bus with a release request, and it can post transfer requests. The controller raises a bus-available signal and tells the device when the bus has become usable. It recognises a descriptor-start request that arrives at one exact cycle of the grant window. For each serviced transfer request it answers with a one-cycle reply strobe and the serviced channel number.

The channel number is three bits wide. Its low two bits leave on a dedicated ID output. The top bit shares the bus-available pin during the strobe cycle. In handshake mode, a transfer request that arrives together with a release request goes straight to a fixed channel (channel 2). A transfer request that arrives alone uses the channel on the request-channel input. With handshake mode off, release requests do nothing and only channels 0 and 1 are accepted.

Top module: `dmahs_ctrl`

## Requirements
- R1: While reset is applied, and in the first cycles after it is released, every output is 0.
- R2: In handshake mode with no request pending, a release request alone raises `bus_avail_o` after the next clock edge. It stays high while the release request stays high and falls after the first edge that samples the release request low.
- R3: `bus_free_o` rises exactly two cycles after `bus_avail_o` rises. It stays high until the grant ends and is never high without `bus_avail_o`.
- R4: `desc_start_o` pulses high for one cycle only when the transfer request is sampled high in the first cycle in which `bus_free_o` is high. A transfer request at any other point of the grant produces neither a descriptor pulse nor a strobe.
- R5: In handshake mode, a transfer request alone with no request pending yields one strobe cycle after the next edge. During that cycle `chan_id_o` is request-channel bits [1:0] and `bus_avail_o` is request-channel bit 2.
- R6: In handshake mode, a transfer request together with a release request yields one strobe cycle for channel 2. During that cycle `chan_id_o` is 2'b10 and `bus_avail_o` is 0, whatever the request-channel input holds.
- R7: With handshake mode off, release requests never raise `bus_avail_o`. Transfer requests for channels 2 to 7 are ignored, and those for channels 0 and 1 are serviced as in R5. Turning handshake mode off during a grant ends the grant after the next edge.
- R8: `reply_stb_o` is never high for two cycles in a row, and `chan_id_o` is 0 whenever the strobe is low. Inputs sampled during a strobe cycle are ignored.
- R9: At most one descriptor pulse occurs per grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_mode_i | input | 1 | Handshake mode enable |
| bus_rel_req_i | input | 1 | Release request from the external device |
| xfer_req_i | input | 1 | Transfer request from the external device |
| req_chan_i | input | 3 | Channel for a transfer request that arrives alone |
| bus_avail_o | output | 1 | Bus available; carries channel bit 2 during the strobe |
| bus_free_o | output | 1 | Data bus usable by the external device |
| reply_stb_o | output | 1 | One-cycle reply strobe |
| chan_id_o | output | 2 | Channel bits [1:0] during the strobe, otherwise 0 |
| desc_start_o | output | 1 | Descriptor-start pulse |

## Verification
A request sampled at an edge shows on the outputs in the cycle after that edge. Bus-available therefore appears one cycle after the release request is driven, and the strobe one cycle after the transfer request is driven. The bus becomes usable two cycles after bus-available rises. The descriptor pulse appears one cycle after the transfer request is driven in that first usable cycle. The driver records the cycle number in which it changes the inputs and queues the expected output set for that cycle plus the delay listed here. The monitor compares the outputs only in the queued cycle, sampling on the falling clock edge. Each scenario includes cycles one step early and one step late, so a design that is off by one cycle produces a mismatch.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_STB   = 2'd2
  } hs_state_e;
endpackage

// File: rtl/dmahs_rst_sync.sv
module dmahs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/dmahs_req_decode.sv
module dmahs_req_decode #(
  parameter int CHAN_W       = 3,
  parameter int DIRECT_CHAN  = 2,
  parameter int LEGACY_CHANS = 2
) (
  input  logic              hs_mode,
  input  logic              rel_req,
  input  logic              xfer_req,
  input  logic [CHAN_W-1:0] req_chan,
  output logic              accept,
  output logic              grant_req,
  output logic [CHAN_W-1:0] chan
);
  localparam logic [CHAN_W-1:0] DIRECT_C = CHAN_W'(DIRECT_CHAN);
  localparam logic [CHAN_W-1:0] LEGACY_C = CHAN_W'(LEGACY_CHANS);

  logic direct;
  logic legal;

  always_comb begin
    direct    = hs_mode && rel_req && xfer_req;
    legal     = hs_mode || (req_chan < LEGACY_C);
    chan      = direct ? DIRECT_C : req_chan;
    accept    = xfer_req && legal;
    grant_req = hs_mode && rel_req && !xfer_req;
  end
endmodule

// File: rtl/dmahs_grant_timer.sv
module dmahs_grant_timer #(
  parameter int GRANT_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic window,
  output logic ready
);
  localparam int CNT_W = $clog2(GRANT_DELAY + 2);
  localparam logic [CNT_W-1:0] DLY = CNT_W'(GRANT_DELAY);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(GRANT_DELAY + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != TOP) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign window = run && (cnt_q == DLY);
  assign ready  = run && (cnt_q >= DLY);
endmodule

// File: rtl/dmahs_pin_mux.sv
module dmahs_pin_mux #(
  parameter int CHAN_W = 3
) (
  input  logic              in_grant,
  input  logic              in_stb,
  input  logic              ready,
  input  logic [CHAN_W-1:0] chan,
  output logic              bus_avail,
  output logic              bus_free,
  output logic              stb,
  output logic [CHAN_W-2:0] chan_id
);
  always_comb begin
    stb       = in_stb;
    bus_avail = in_stb ? chan[CHAN_W-1] : in_grant;
    chan_id   = in_stb ? chan[CHAN_W-2:0] : '0;
    bus_free  = in_grant && ready;
  end
endmodule

// File: rtl/dmahs_ctrl.sv
module dmahs_ctrl
  import dmahs_pkg::*;
#(
  parameter int CHAN_W       = 3,
  parameter int GRANT_DELAY  = 2,
  parameter int DIRECT_CHAN  = 2,
  parameter int LEGACY_CHANS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_mode_i,
  input  logic              bus_rel_req_i,
  input  logic              xfer_req_i,
  input  logic [CHAN_W-1:0] req_chan_i,
  output logic              bus_avail_o,
  output logic              bus_free_o,
  output logic              reply_stb_o,
  output logic [CHAN_W-2:0] chan_id_o,
  output logic              desc_start_o
);
  logic              rst_sn;
  hs_state_e         state_q, state_d;
  logic [CHAN_W-1:0] chan_q, dec_chan;
  logic              chan_en;
  logic              desc_q, desc_d;
  logic              dec_accept, dec_grant;
  logic              win, rdy;
  logic              st_idle, st_grant, st_stb;

  dmahs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  dmahs_req_decode #(
    .CHAN_W(CHAN_W), .DIRECT_CHAN(DIRECT_CHAN), .LEGACY_CHANS(LEGACY_CHANS)
  ) u_dec (
    .hs_mode(hs_mode_i), .rel_req(bus_rel_req_i), .xfer_req(xfer_req_i),
    .req_chan(req_chan_i), .accept(dec_accept), .grant_req(dec_grant),
    .chan(dec_chan)
  );

  assign st_idle  = (state_q == ST_IDLE);
  assign st_grant = (state_q == ST_GRANT);
  assign st_stb   = (state_q == ST_STB);

  dmahs_grant_timer #(.GRANT_DELAY(GRANT_DELAY)) u_tmr (
    .clk(clk), .rst_n(rst_sn), .run(st_grant), .window(win), .ready(rdy)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    chan_en = 1'b0;
    desc_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (dec_accept) begin
          state_d = ST_STB;
          chan_en = 1'b1;
        end else if (dec_grant) begin
          state_d = ST_GRANT;
        end
      end
      ST_GRANT: begin
        if (!hs_mode_i || !bus_rel_req_i) state_d = ST_IDLE;
        else desc_d = win && xfer_req_i;
      end
      ST_STB:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      desc_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      desc_q  <= desc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      chan_q <= '0;
    else if (chan_en) chan_q <= dec_chan;
  end

  dmahs_pin_mux #(.CHAN_W(CHAN_W)) u_mux (
    .in_grant(st_grant), .in_stb(st_stb), .ready(rdy), .chan(chan_q),
    .bus_avail(bus_avail_o), .bus_free(bus_free_o), .stb(reply_stb_o),
    .chan_id(chan_id_o)
  );

  assign desc_start_o = desc_q;
endmodule

// File: rtl/dmahs_ctrl_chk.sv
module dmahs_ctrl_chk #(
  parameter int CHAN_W       = 3,
  parameter int DIRECT_CHAN  = 2,
  parameter int LEGACY_CHANS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idle,
  input logic              hs_mode,
  input logic              rel_req,
  input logic              xfer_req,
  input logic [CHAN_W-1:0] req_chan,
  input logic              bus_avail,
  input logic              bus_free,
  input logic              stb,
  input logic [CHAN_W-2:0] chan_id,
  input logic              desc
);
  localparam logic [CHAN_W-1:0] DC = CHAN_W'(DIRECT_CHAN);
  localparam logic [CHAN_W-1:0] LC = CHAN_W'(LEGACY_CHANS);

  AST_AVAIL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_avail) && !stb) |-> $past(hs_mode && rel_req)); // R2
  AST_FREE_WITH_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |-> (bus_avail && !stb)); // R3
  AST_FREE_AFTER_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(bus_avail)); // R3
  AST_DESC_IN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    desc |-> (bus_free && !stb)); // R4
  AST_DIRECT_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && hs_mode && rel_req && xfer_req) |=>
      (stb && chan_id == DC[CHAN_W-2:0] && bus_avail == DC[CHAN_W-1])); // R6
  AST_LEGACY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !hs_mode && xfer_req && req_chan >= LC) |=> !stb); // R7
  AST_LEGACY_NO_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_mode |=> !bus_avail); // R7
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb); // R8
  AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |-> (chan_id == '0)); // R8
  AST_DESC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    desc |=> !desc); // R9
endmodule

bind dmahs_ctrl dmahs_ctrl_chk #(
  .CHAN_W(CHAN_W), .DIRECT_CHAN(DIRECT_CHAN), .LEGACY_CHANS(LEGACY_CHANS)
) u_chk (
  .clk(clk), .rst_n(rst_sn), .idle(st_idle), .hs_mode(hs_mode_i),
  .rel_req(bus_rel_req_i), .xfer_req(xfer_req_i), .req_chan(req_chan_i),
  .bus_avail(bus_avail_o), .bus_free(bus_free_o), .stb(reply_stb_o),
  .chan_id(chan_id_o), .desc(desc_start_o)
);

// File: tb/sim_dmahs_ctrl.sv
`timescale 1ns/1ps
module sim_dmahs_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hs_mode, rel, xfer;
  logic [2:0] ch;
  logic       av, fr, stb, de;
  logic [1:0] id;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         at;
    logic       av, fr, st;
    logic [1:0] id;
    logic       de;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dmahs_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hs_mode_i(hs_mode), .bus_rel_req_i(rel),
    .xfer_req_i(xfer), .req_chan_i(ch), .bus_avail_o(av), .bus_free_o(fr),
    .reply_stb_o(stb), .chan_id_o(id), .desc_start_o(de)
  );

  task automatic expect_at(int at, logic a, logic f, logic s, logic [1:0] i,
                           logic d, string tag);
    exp_t e;
    e.at = at; e.av = a; e.fr = f; e.st = s; e.id = i; e.de = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(logic h, logic r, logic x, logic [2:0] c);
    hs_mode = h; rel = r; xfer = x; ch = c;
  endtask

  // monitor: compares queued items in their due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at != cyc || {av, fr, stb, id, de} !== {e.av, e.fr, e.st, e.id, e.de}) begin
        errors++;
        $display("FAIL %s cyc %0d: got avail=%b free=%b stb=%b id=%b desc=%b, exp avail=%b free=%b stb=%b id=%b desc=%b (due %0d)",
                 e.tag, cyc, av, fr, stb, id, de, e.av, e.fr, e.st, e.id, e.de, e.at);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0;
    drive(1, 0, 0, 3'd0);
    tick(); tick();
    checks++;
    if ({av, fr, stb, id, de} !== 6'b0) begin
      errors++;
      $display("FAIL R1 in reset: got %b exp 000000", {av, fr, stb, id, de});
    end
    rst_n = 1'b1;
    tick(); c = cyc;
    expect_at(c + 1, 0, 0, 0, 2'b00, 0, "R1");
    tick(); tick(); tick(); tick();

    // R5: plain transfer request, channel 5 then 3
    drive(1, 0, 1, 3'd5); c = cyc;
    expect_at(c + 1, 1, 0, 1, 2'b01, 0, "R5");
    expect_at(c + 2, 0, 0, 0, 2'b00, 0, "R5");
    tick(); drive(1, 0, 0, 3'd0);
    tick(); drive(1, 0, 1, 3'd3); c = cyc;
    expect_at(c + 1, 0, 0, 1, 2'b11, 0, "R5");
    tick(); drive(1, 0, 0, 3'd0);
    tick();

    // R6: simultaneous release and transfer -> channel 2
    drive(1, 1, 1, 3'd7); c = cyc;
    expect_at(c + 1, 0, 0, 1, 2'b10, 0, "R6");
    expect_at(c + 2, 0, 0, 0, 2'b00, 0, "R6");
    tick(); drive(1, 0, 0, 3'd0);
    tick(); tick();

    // R8: request held into the strobe cycle is ignored
    drive(1, 0, 1, 3'd6); c = cyc;
    expect_at(c + 1, 1, 0, 1, 2'b10, 0, "R8");
    expect_at(c + 2, 0, 0, 0, 2'b00, 0, "R8");
    expect_at(c + 3, 0, 0, 0, 2'b00, 0, "R8");
    tick(); drive(1, 0, 1, 3'd1);
    tick(); drive(1, 0, 0, 3'd0);
    tick(); tick();

    // R2/R3/R4/R9: grant with descriptor on time
    drive(1, 1, 0, 3'd0); c = cyc;
    expect_at(c + 1, 1, 0, 0, 2'b00, 0, "R2");
    expect_at(c + 2, 1, 0, 0, 2'b00, 0, "R3");
    expect_at(c + 3, 1, 1, 0, 2'b00, 0, "R3");
    expect_at(c + 4, 1, 1, 0, 2'b00, 1, "R4");
    expect_at(c + 5, 1, 1, 0, 2'b00, 0, "R9");
    expect_at(c + 6, 0, 0, 0, 2'b00, 0, "R2");
    tick(); tick(); tick(); drive(1, 1, 1, 3'd0);
    tick(); drive(1, 1, 1, 3'd0);
    tick(); drive(1, 0, 0, 3'd0);
    tick(); tick();

    // R4: transfer request one cycle early and one cycle late
    drive(1, 1, 0, 3'd0); c = cyc;
    expect_at(c + 1, 1, 0, 0, 2'b00, 0, "R2");
    expect_at(c + 3, 1, 1, 0, 2'b00, 0, "R4");
    expect_at(c + 4, 1, 1, 0, 2'b00, 0, "R4");
    expect_at(c + 5, 1, 1, 0, 2'b00, 0, "R4");
    expect_at(c + 6, 0, 0, 0, 2'b00, 0, "R2");
    tick(); tick(); drive(1, 1, 1, 3'd0);
    tick(); drive(1, 1, 0, 3'd0);
    tick(); drive(1, 1, 1, 3'd0);
    tick(); drive(1, 0, 0, 3'd0);
    tick(); tick();

    // R7: handshake mode off mid-grant ends the grant
    drive(1, 1, 0, 3'd0); c = cyc;
    expect_at(c + 1, 1, 0, 0, 2'b00, 0, "R2");
    expect_at(c + 2, 0, 0, 0, 2'b00, 0, "R7");
    expect_at(c + 3, 0, 0, 0, 2'b00, 0, "R7");
    tick(); drive(0, 1, 0, 3'd0);
    tick(); tick(); drive(0, 0, 0, 3'd0);
    tick();

    // R7: legacy mode rejects channel 2, accepts channel 1 even with release
    drive(0, 1, 1, 3'd2); c = cyc;
    expect_at(c + 1, 0, 0, 0, 2'b00, 0, "R7");
    expect_at(c + 2, 0, 0, 0, 2'b00, 0, "R7");
    tick(); tick(); drive(0, 1, 1, 3'd1); c = cyc;
    expect_at(c + 1, 0, 0, 1, 2'b01, 0, "R7");
    expect_at(c + 2, 0, 0, 0, 2'b00, 0, "R7");
    tick(); drive(0, 0, 0, 3'd0);
    tick(); tick(); tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule